// File: doc/BRIEF.md
# Indirect Per-Peripheral Wake-Up Enable Register

This block is one 32-bit control word on a peripheral bus. Through it, software reaches a whole bank of wake-up enable bits, one bit per peripheral identifier. Each write carries three fields: an identifier, a command bit and an enable value.

A write in command mode changes the enable bit of the chosen peripheral. A write in query mode only records which identifier later reads should describe. A read returns that identifier together with two more values: the stored enable bit, and the live activity level the peripheral presents on its input. Software uses the activity bit to see whether turning the wake-up on is safe.

A global write-protection input freezes the register. A parameter mask fixes which identifiers may hold an enable at all; the bits of every other identifier stay zero. If software enables a peripheral that is active at that moment, the value is still stored, and a sticky error output is raised and held until reset.

Top module: `pwake_ctl`

## Requirements
- R1: After reset every wake-up enable output is 0, the sticky error is 0, and a read of the register returns 0x00000000.
- R2: A bus write to byte offset 0x148 with bit 12 (command) equal to 1 stores bit 28 into the enable of the identifier in bits [6:0], visible on `wake_en` after the next rising clock edge, when that identifier is eligible and protection is off.
- R3: While `wp_lock` is 1, a write to the register changes nothing: the enables, the recorded identifier and the sticky error all keep their values.
- R4: An identifier is eligible only if it is at least 2, below `NUM_ID`, and its bit in `ELIG_MASK` is 1. A write to any other identifier leaves every enable unchanged, and those identifiers' enables are always 0.
- R5: An accepted write, whatever its command bit, records bits [6:0] as the identifier for later reads. With bit 12 equal to 0 no enable is changed.
- R6: A read of offset 0x148 returns, in the same cycle, the recorded identifier in [6:0], 0 in bit 12, that identifier's stored enable in bit 28, and its live activity input in bit 16 (0 for an ineligible identifier). All other bits are 0.
- R7: A read of any other offset, and any cycle without a read of the register, gives 0 on `bus_rdata`. A write to any other offset changes nothing.
- R8: An accepted enable write of 1 to an eligible identifier whose activity input is 1 stores the 1 and sets `busy_en_err`. Once set, `busy_en_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wp_lock | input | 1 | Write protection; 1 blocks all writes |
| periph_busy | input | NUM_ID | Live activity level of each peripheral |
| wake_en | output | NUM_ID | Stored wake-up enable of each peripheral |
| busy_en_err | output | 1 | Sticky flag: an active peripheral was enabled |

## Verification
Every enable bit is visible on `wake_en` one edge after the write that targets it. A wrong enable update, or an update that leaks to a neighbouring identifier, therefore shows up in the cycle after the faulty write. A wrong recorded identifier stays hidden until the next read, which then returns the wrong identifier, enable and activity bits at once. A sticky flag that clears or fails to set shows on `busy_en_err` one cycle after the write that should have set it. Random reads between writes keep the hidden recorded identifier under frequent observation.

// File: rtl/pwake_pkg.sv
package pwake_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ID_W    = 7;
    localparam int unsigned ID_SPAN = 1 << ID_W;
    localparam int unsigned CMD_BIT = 12;
    localparam int unsigned ACT_BIT = 16;
    localparam int unsigned EN_BIT  = 28;
    localparam int unsigned MIN_ID  = 2;
    localparam logic [11:0] REG_OFS = 12'h148;

    typedef logic [ID_W-1:0]   pid_t;
    typedef logic [WORD_W-1:0] word_t;

    // Fields pulled out of a write word
    typedef struct packed {
        pid_t id;
        logic cmd;
        logic val;
    } wfield_t;

    function automatic wfield_t split_word(word_t w);
        wfield_t f;
        f.id  = w[ID_W-1:0];
        f.cmd = w[CMD_BIT];
        f.val = w[EN_BIT];
        return f;
    endfunction

    function automatic word_t build_status(pid_t id, logic en, logic act);
        word_t w;
        w             = '0;
        w[ID_W-1:0]   = id;
        w[ACT_BIT]    = act;
        w[EN_BIT]     = en;
        return w;
    endfunction

endpackage

// File: rtl/pwake_elig.sv
module pwake_elig
    import pwake_pkg::*;
#(
    parameter int unsigned            NUM_ID    = 48,
    parameter logic [ID_SPAN-1:0]     ELIG_MASK = '0
) (
    output logic [ID_SPAN-1:0] elig_pad
);

    logic [NUM_ID-1:0] elig_vec;

    // One bit per implemented identifier; the lowest IDs are never eligible
    for (genvar g = 0; g < NUM_ID; g++) begin : g_elig
        if (g >= MIN_ID) begin : g_on
            assign elig_vec[g] = ELIG_MASK[g];
        end else begin : g_off
            assign elig_vec[g] = 1'b0;
        end
    end

    // Pad to the full identifier space so any 7-bit ID can index it
    always_comb begin
        elig_pad = '0;
        for (int i = 0; i < int'(NUM_ID); i++) begin
            elig_pad[i] = elig_vec[i];
        end
    end

endmodule

// File: rtl/pwake_bank.sv
module pwake_bank
    import pwake_pkg::*;
#(
    parameter int unsigned NUM_ID = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_stb,
    input  pid_t               upd_id,
    input  logic               upd_val,
    input  logic [NUM_ID-1:0]  elig_vec,
    output logic [NUM_ID-1:0]  en_q
);

    logic [NUM_ID-1:0] en_d;

    // Each enable bit has its own write decode
    for (genvar g = 0; g < NUM_ID; g++) begin : g_bit
        always_comb begin
            en_d[g] = en_q[g];
            if (upd_stb && (upd_id == pid_t'(g)) && elig_vec[g]) begin
                en_d[g] = upd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/pwake_front.sv
module pwake_front
    import pwake_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  wfield_t           wf,
    input  logic              wp_lock,
    input  logic              id_ok,
    input  logic              id_busy,
    output logic              upd_stb,
    output logic              rd_hit,
    output pid_t              sel_id,
    output logic              err
);

    typedef struct packed {
        pid_t sel_id;
        logic err;
    } fstate_t;

    fstate_t st_d, st_q;
    logic    addr_hit;
    logic    wr_go;

    always_comb begin
        addr_hit = (bus_addr == ADDR_W'(REG_OFS));
        wr_go    = bus_sel && bus_wr && addr_hit && !wp_lock;
        rd_hit   = bus_sel && !bus_wr && addr_hit;
        upd_stb  = wr_go && wf.cmd && id_ok;

        st_d = st_q;
        if (wr_go) begin
            st_d.sel_id = wf.id;
        end
        if (upd_stb && wf.val && id_busy) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_id = st_q.sel_id;
    assign err    = st_q.err;

endmodule

// File: rtl/pwake_ctl.sv
module pwake_ctl
    import pwake_pkg::*;
#(
    parameter int unsigned        NUM_ID    = 48,
    parameter int unsigned        ADDR_W    = 9,
    parameter logic [ID_SPAN-1:0] ELIG_MASK = 128'h0000_0000_0000_0000_0000_F0F0_3C0C_FF3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wp_lock,
    input  logic [NUM_ID-1:0] periph_busy,
    output logic [NUM_ID-1:0] wake_en,
    output logic              busy_en_err
);

    initial begin
        if (NUM_ID > ID_SPAN || NUM_ID <= MIN_ID) $error("NUM_ID out of range");
        if (ADDR_W < 9) $error("ADDR_W too narrow for the register offset");
    end

    wfield_t              wf;
    logic [ID_SPAN-1:0]   elig_pad;
    logic [ID_SPAN-1:0]   busy_pad;
    logic [ID_SPAN-1:0]   en_pad;
    logic                 upd_stb;
    logic                 rd_hit;
    pid_t                 sel_id;
    logic                 unused_wdata;

    assign wf           = split_word(bus_wdata);
    assign unused_wdata = ^{bus_wdata[31:29], bus_wdata[27:13], bus_wdata[11:7]};

    always_comb begin
        busy_pad = '0;
        en_pad   = '0;
        for (int i = 0; i < int'(NUM_ID); i++) begin
            busy_pad[i] = periph_busy[i];
            en_pad[i]   = wake_en[i];
        end
    end

    pwake_elig #(
        .NUM_ID    (NUM_ID),
        .ELIG_MASK (ELIG_MASK)
    ) u_elig (
        .elig_pad  (elig_pad)
    );

    pwake_front #(
        .ADDR_W   (ADDR_W)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wf       (wf),
        .wp_lock  (wp_lock),
        .id_ok    (elig_pad[wf.id]),
        .id_busy  (busy_pad[wf.id]),
        .upd_stb  (upd_stb),
        .rd_hit   (rd_hit),
        .sel_id   (sel_id),
        .err      (busy_en_err)
    );

    pwake_bank #(
        .NUM_ID   (NUM_ID)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_stb  (upd_stb),
        .upd_id   (wf.id),
        .upd_val  (wf.val),
        .elig_vec (elig_pad[NUM_ID-1:0]),
        .en_q     (wake_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata = build_status(sel_id, en_pad[sel_id],
                                     elig_pad[sel_id] & busy_pad[sel_id]);
        end
    end

endmodule

// File: rtl/pwake_ctl_chk.sv
module pwake_ctl_chk #(
    parameter int unsigned  NUM_ID    = 48,
    parameter int unsigned  ADDR_W    = 9,
    parameter logic [127:0] ELIG_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              wp_lock,
    input logic [NUM_ID-1:0] periph_busy,
    input logic [NUM_ID-1:0] wake_en,
    input logic              busy_en_err
);

    localparam logic [31:0] SPARE_BITS = ~(32'h7F | (32'h1 << 16) | (32'h1 << 28));

    logic [127:0] ok_pad;
    logic [127:0] en_wide;
    logic [6:0]   w_id;
    logic         is_reg;
    logic         pend_q;
    logic [6:0]   pend_id_q;
    logic         pend_val_q;
    logic         unused_busy;

    assign unused_busy = ^periph_busy;

    always_comb begin
        ok_pad  = '0;
        en_wide = '0;
        for (int i = 2; i < int'(NUM_ID); i++) ok_pad[i] = ELIG_MASK[i];
        for (int i = 0; i < int'(NUM_ID); i++) en_wide[i] = wake_en[i];
    end

    assign w_id   = bus_wdata[6:0];
    assign is_reg = (bus_addr == ADDR_W'(12'h148));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_id_q  <= '0;
            pend_val_q <= 1'b0;
        end else begin
            pend_q     <= bus_sel && bus_wr && is_reg && !wp_lock && bus_wdata[12] && ok_pad[w_id];
            pend_id_q  <= w_id;
            pend_val_q <= bus_wdata[28];
        end
    end

    a_r2_enable_stored: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> en_wide[pend_id_q] == pend_val_q);

    a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && wp_lock) |=> ($stable(wake_en) && $stable(busy_en_err)));

    a_r4_ineligible_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wide & ~ok_pad) == '0);

    a_r6_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & SPARE_BITS) == '0 && bus_rdata[12] == 1'b0);

    a_r7_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr || !is_reg) |-> bus_rdata == '0);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy_en_err |=> busy_en_err);

endmodule

bind pwake_ctl pwake_ctl_chk #(
    .NUM_ID    (NUM_ID),
    .ADDR_W    (ADDR_W),
    .ELIG_MASK (ELIG_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wp_lock     (wp_lock),
    .periph_busy (periph_busy),
    .wake_en     (wake_en),
    .busy_en_err (busy_en_err)
);

// File: tb/pwake_ctl_test.sv
module pwake_ctl_test;

    localparam int unsigned  NUM_ID = 48;
    localparam int unsigned  ADDR_W = 9;
    localparam logic [127:0] MASK   = 128'h0000_0000_0000_0000_0000_F0F0_3C0C_FF3C;
    localparam logic [8:0]   OFS    = 9'h148;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wp_lock = 1'b0;
    logic [NUM_ID-1:0] periph_busy = '0;
    logic [NUM_ID-1:0] wake_en;
    logic              busy_en_err;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    logic [127:0] m_en = '0;
    logic [6:0]   m_id = '0;
    logic         m_err = 1'b0;

    always #10 clk = ~clk;

    pwake_ctl #(
        .NUM_ID    (NUM_ID),
        .ADDR_W    (ADDR_W),
        .ELIG_MASK (MASK)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wp_lock     (wp_lock),
        .periph_busy (periph_busy),
        .wake_en     (wake_en),
        .busy_en_err (busy_en_err)
    );

    function automatic bit elig(logic [6:0] id);
        return (id >= 2) && (int'(id) < int'(NUM_ID)) && MASK[id];
    endfunction

    function automatic logic [31:0] exp_word(logic [NUM_ID-1:0] busy);
        logic [31:0] w = '0;
        w[6:0] = m_id;
        if (elig(m_id)) begin
            w[28] = m_en[m_id];
            w[16] = busy[m_id];
        end
        return w;
    endfunction

    function automatic logic [31:0] mk(logic [6:0] id, logic cmd, logic val);
        logic [31:0] w = '0;
        w[6:0] = id;
        w[12]  = cmd;
        w[28]  = val;
        return w;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, check read data before the
    // rising edge, update the model after it and check the state outputs.
    task automatic op(logic wr, logic [8:0] addr, logic [31:0] data,
                      logic lock, logic [NUM_ID-1:0] busy, string tag);
        @(negedge clk);
        bus_sel     = 1'b1;
        bus_wr      = wr;
        bus_addr    = addr;
        bus_wdata   = data;
        wp_lock     = lock;
        periph_busy = busy;
        #2;
        if (!wr) begin
            logic [31:0] e;
            e = (addr == OFS) ? exp_word(busy) : 32'h0;
            check(bus_rdata == e, tag, 64'(bus_rdata), 64'(e));
        end
        @(posedge clk);
        #1;
        if (wr && addr == OFS && !lock) begin
            m_id = data[6:0];
            if (data[12] && elig(data[6:0])) begin
                m_en[data[6:0]] = data[28];
                if (data[28] && busy[data[6:0]]) m_err = 1'b1;
            end
        end
        bus_sel = 1'b0;
        check(wake_en == m_en[NUM_ID-1:0], tag, 64'(wake_en), 64'(m_en[NUM_ID-1:0]));
        check(busy_en_err == m_err, tag, 64'(busy_en_err), 64'(m_err));
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state, read while in reset and after release
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = OFS; periph_busy = '1;
        #35;
        check(bus_rdata == 32'h0, "R1", 64'(bus_rdata), 64'h0);
        check(wake_en == '0, "R1", 64'(wake_en), 64'h0);
        check(busy_en_err == 1'b0, "R1", 64'(busy_en_err), 64'h0);
        bus_sel = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        op(1'b0, OFS, 32'h0, 1'b0, '1, "R1");

        // R2 / R6: enable and clear an eligible ID, read back
        op(1'b1, OFS, mk(7'd2, 1'b1, 1'b1), 1'b0, '0, "R2");
        op(1'b0, OFS, 32'h0, 1'b0, 48'h4, "R6");
        op(1'b1, OFS, mk(7'd15, 1'b1, 1'b1), 1'b0, '0, "R2");
        op(1'b1, OFS, mk(7'd2, 1'b1, 1'b0), 1'b0, '0, "R2");
        op(1'b0, OFS, 32'h0, 1'b0, '1, "R6");

        // R3: protected writes change nothing, recorded ID kept
        op(1'b1, OFS, mk(7'd3, 1'b1, 1'b1), 1'b1, '1, "R3");
        op(1'b1, OFS, mk(7'd15, 1'b1, 1'b0), 1'b1, '0, "R3");
        op(1'b0, OFS, 32'h0, 1'b1, '1, "R3");

        // R4: ID 0, 1, masked-off ID, IDs beyond NUM_ID
        op(1'b1, OFS, mk(7'd0, 1'b1, 1'b1), 1'b0, '0, "R4");
        op(1'b1, OFS, mk(7'd1, 1'b1, 1'b1), 1'b0, '0, "R4");
        op(1'b1, OFS, mk(7'd6, 1'b1, 1'b1), 1'b0, '0, "R4");
        op(1'b0, OFS, 32'h0, 1'b0, '1, "R4");
        op(1'b1, OFS, mk(7'd127, 1'b1, 1'b1), 1'b0, '0, "R4");
        op(1'b1, OFS, mk(7'd48, 1'b1, 1'b1), 1'b0, '0, "R4");

        // R5: query-mode write records ID only
        op(1'b1, OFS, mk(7'd9, 1'b0, 1'b1), 1'b0, '0, "R5");
        op(1'b0, OFS, 32'h0, 1'b0, 48'h200, "R5");

        // R7: other offsets
        op(1'b0, 9'h14C, 32'h0, 1'b0, '1, "R7");
        op(1'b1, 9'h14C, mk(7'd10, 1'b1, 1'b1), 1'b0, '0, "R7");
        op(1'b1, 9'h048, mk(7'd11, 1'b1, 1'b1), 1'b0, '0, "R7");

        // R8: enabling an active peripheral
        op(1'b1, OFS, mk(7'd10, 1'b1, 1'b0), 1'b0, 48'h400, "R8");
        op(1'b1, OFS, mk(7'd10, 1'b1, 1'b1), 1'b0, 48'h400, "R8");
        op(1'b1, OFS, mk(7'd10, 1'b1, 1'b0), 1'b0, '0, "R8");
        op(1'b0, OFS, 32'h0, 1'b0, 48'h400, "R8");

        // Random traffic
        for (int k = 0; k < 600; k++) begin
            logic              wr, lock, cmd, val;
            logic [8:0]        addr;
            logic [6:0]        id;
            logic [NUM_ID-1:0] busy;
            logic [31:0]       data;
            wr   = ($urandom % 3) != 0;
            lock = ($urandom % 8) == 0;
            addr = (($urandom % 6) == 0) ? 9'($urandom) : OFS;
            id   = (($urandom % 10) == 0) ? 7'($urandom) : 7'($urandom % 52);
            cmd  = ($urandom % 4) != 0;
            val  = $urandom % 2;
            busy = NUM_ID'({$urandom, $urandom}) & NUM_ID'({$urandom, $urandom});
            data = mk(id, cmd, val) | ($urandom & 32'hEFFE_EF80);
            op(wr, addr, data, lock, busy, wr ? "R2" : "R6");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule